// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block turns eight level-sensitive I/O interrupt lines into posted message writes aimed at a CPU. Software programs it through three registers: a select register that points into an internal table, a window register that reads or writes the table word the select register points at, and an end-of-interrupt register. For every line the table holds two words. The control word carries a 6-bit vector, a mask bit and three mode bits. The destination word carries a packed CPU address.

When a line rises, is unmasked and has a nonzero destination word, the block sets one of eight pending bits. The low three bits of that line's vector choose which bit. If that pending bit was clear beforehand, the block queues one message: the vector is the data and the unpacked destination is the address. Messages leave on a request/acknowledge port, lowest line first, one per acknowledge. A line that falls clears its selected pending bit. A line that rises while it cannot deliver also clears its selected pending bit. An end-of-interrupt write clears the pending bits of every line whose vector matches the written value.

Outside the block, the interrupt of a PCI device in slot s is wired to line s modulo 8.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After synchronous reset, no message is offered and every pending bit is clear. The control word of line i reads 0x0001A000 | (i+2): bit 16 is the mask, bit 15 is level mode and bit 13 is low polarity. Each destination word reads the DEST_RST parameter, which defaults to 0x00FE0000.
- R2: A read request (cfg_rd) returns its data on cfg_rdata with cfg_rvalid high in the next cycle, and cfg_rvalid is low in every other cycle. Register code 0 is the select register, which reads back its 8-bit value. Code 1 is the window and code 2 is the end-of-interrupt register, which reads 0.
- R3: Window index 0x01 reads 0x00200001, which gives a table size of 32 words in bits [31:16] and 1 in the low bits. Other indices below 0x10 read 0 and ignore writes. Indices 0x20 and above read 0xFFFFFFFF and ignore writes.
- R4: Window index 0x10+2i holds the control word of line i and 0x11+2i holds its destination word. A rising line that is unmasked (bit 16 clear) and has a nonzero destination word produces one message whose data is the low 6 bits of the control word, zero-extended.
- R5: A rising line that is masked, or whose destination word is zero, produces no message. Control bits 15, 13 and 8 are stored and read back but do not affect delivery.
- R6: The message address is 0xF in bits [31:28], destination bits [23:16] in bits [27:20], destination bits [31:24] in bits [19:12], and zero in bits [11:0].
- R7: The pending bit a line uses is its vector's low 3 bits. If a line rises while its pending bit is already set, no message is produced. A falling line clears its pending bit.
- R8: A write to register code 2 compares its low 6 bits with every line's 6-bit vector and clears the pending bit of each line that matches. A value that matches no vector leaves the pending bits unchanged.
- R9: Lines that become deliverable in the same cycle are sent lowest index first, one per accepted transfer. While msg_valid is high and msg_ack is low, msg_addr and msg_data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Level interrupt lines |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 2 | Register code: 0 select, 1 window, 2 end-of-interrupt |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| msg_valid | output | 1 | Message write request |
| msg_ack | input | 1 | Message accepted when high together with msg_valid |
| msg_addr | output | 32 | Unpacked CPU destination address |
| msg_data | output | 32 | Zero-extended 6-bit vector |

## Verification
The bench raises a single unmasked line and compares the message that comes out. It also raises a line while it is masked, and a line whose destination word is zero, which separates the delivery gate from the edge detector. Two lines that share one pending bit are raised one after the other: the first delivers and the second stays silent, unless an end-of-interrupt that matches the first vector, or a fall of the second line, comes in between. An end-of-interrupt that matches no vector must change nothing. Three lines raised together while the acknowledge is held low show the hold of the message port and the lowest-index-first order.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int WORD_W  = 32;
  localparam int VEC_W   = 6;
  localparam int BIT_MSK = 16;
  localparam int FIRST_LINE_IDX = 16;

  localparam logic [1:0] REG_SEL = 2'd0;
  localparam logic [1:0] REG_WIN = 2'd1;
  localparam logic [1:0] REG_EOI = 2'd2;

  // masked, level mode, low polarity; vector added per line
  localparam logic [WORD_W-1:0] CTRL_RST_BASE = 32'h0001_A000;

  function automatic logic [WORD_W-1:0] unpack_dest(input logic [WORD_W-1:0] d);
    return {4'hF, d[23:16], d[31:24], 12'h000};
  endfunction
endpackage

// File: rtl/irqr_regs.sv
module irqr_regs
  import irqr_pkg::*;
#(
  parameter int LINES = 8,
  parameter int SEL_W = 8,
  parameter logic [31:0] DEST_RST = 32'h00FE_0000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_wr,
  input  logic                         cfg_rd,
  input  logic [1:0]                   cfg_addr,
  input  logic [WORD_W-1:0]            cfg_wdata,
  output logic [WORD_W-1:0]            cfg_rdata,
  output logic                         cfg_rvalid,
  output logic [LINES-1:0][WORD_W-1:0] ctrl_o,
  output logic [LINES-1:0][WORD_W-1:0] dest_o,
  output logic                         eoi_valid,
  output logic [VEC_W-1:0]             eoi_vec
);
  localparam int LW          = $clog2(LINES);
  localparam int TABLE_WORDS = FIRST_LINE_IDX + 2 * LINES;
  localparam logic [SEL_W-1:0] IDX_VER  = SEL_W'(1);
  localparam logic [SEL_W-1:0] IDX_BASE = SEL_W'(FIRST_LINE_IDX);
  localparam logic [SEL_W-1:0] IDX_END  = SEL_W'(TABLE_WORDS);
  localparam logic [WORD_W-1:0] VERSION = {16'(TABLE_WORDS), 16'h0001};

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] rel;
  logic [LW-1:0]    line;
  logic             in_lines;
  logic             win_wr;
  logic [WORD_W-1:0] rd_d;

  assign rel      = sel_q - IDX_BASE;
  assign line     = rel[LW:1];
  assign in_lines = (sel_q >= IDX_BASE) && (sel_q < IDX_END);
  assign win_wr   = cfg_wr && (cfg_addr == REG_WIN) && in_lines;

  assign eoi_valid = cfg_wr && (cfg_addr == REG_EOI);
  assign eoi_vec   = cfg_wdata[VEC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (cfg_wr && cfg_addr == REG_SEL) sel_q <= cfg_wdata[SEL_W-1:0];
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_o[i] <= CTRL_RST_BASE | WORD_W'(i + 2);
        dest_o[i] <= DEST_RST;
      end else if (win_wr && line == LW'(i)) begin
        if (sel_q[0]) dest_o[i] <= cfg_wdata;
        else          ctrl_o[i] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    rd_d = '1;
    case (cfg_addr)
      REG_SEL: rd_d = WORD_W'(sel_q);
      REG_WIN: begin
        if (sel_q == IDX_VER)       rd_d = VERSION;
        else if (sel_q < IDX_BASE)  rd_d = '0;
        else if (in_lines)          rd_d = sel_q[0] ? dest_o[line] : ctrl_o[line];
        else                        rd_d = '1;
      end
      REG_EOI: rd_d = '0;
      default: rd_d = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) cfg_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/irqr_events.sv
module irqr_events
  import irqr_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LINES-1:0]             irq_in,
  input  logic [LINES-1:0][WORD_W-1:0] ctrl_i,
  input  logic [LINES-1:0][WORD_W-1:0] dest_i,
  input  logic                         eoi_valid,
  input  logic [VEC_W-1:0]             eoi_vec,
  input  logic                         take_valid,
  input  logic [$clog2(LINES)-1:0]     take_idx,
  output logic [LINES-1:0]             msg_req
);
  localparam int PW = $clog2(LINES);

  logic [LINES-1:0] irq_q;
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] pend_d;
  logic [LINES-1:0] req_d;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] fall;

  assign rise = irq_in & ~irq_q;
  assign fall = ~irq_in & irq_q;

  // end-of-interrupt first, then line events in index order
  always_comb begin
    pend_d = pend_q;
    req_d  = msg_req;
    if (take_valid) req_d[take_idx] = 1'b0;
    if (eoi_valid) begin
      for (int i = 0; i < LINES; i++) begin
        if (ctrl_i[i][VEC_W-1:0] == eoi_vec) pend_d[ctrl_i[i][PW-1:0]] = 1'b0;
      end
    end
    for (int i = 0; i < LINES; i++) begin
      if (rise[i]) begin
        if (!ctrl_i[i][BIT_MSK] && dest_i[i] != '0) begin
          if (!pend_d[ctrl_i[i][PW-1:0]]) req_d[i] = 1'b1;
          pend_d[ctrl_i[i][PW-1:0]] = 1'b1;
        end else begin
          pend_d[ctrl_i[i][PW-1:0]] = 1'b0;
        end
      end else if (fall[i]) begin
        pend_d[ctrl_i[i][PW-1:0]] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= '0;
      pend_q  <= '0;
      msg_req <= '0;
    end else begin
      irq_q   <= irq_in;
      pend_q  <= pend_d;
      msg_req <= req_d;
    end
  end
endmodule

// File: rtl/irqr_sender.sv
module irqr_sender
  import irqr_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LINES-1:0]             msg_req,
  input  logic [LINES-1:0][WORD_W-1:0] ctrl_i,
  input  logic [LINES-1:0][WORD_W-1:0] dest_i,
  input  logic                         msg_ack,
  output logic                         msg_valid,
  output logic [WORD_W-1:0]            msg_addr,
  output logic [WORD_W-1:0]            msg_data,
  output logic                         take_valid,
  output logic [$clog2(LINES)-1:0]     take_idx
);
  localparam int LW = $clog2(LINES);

  always_comb begin
    take_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (msg_req[i]) take_idx = LW'(i);
    end
  end

  assign take_valid = (|msg_req) && (!msg_valid || msg_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (take_valid) begin
      msg_valid <= 1'b1;
      msg_addr  <= unpack_dest(dest_i[take_idx]);
      msg_data  <= WORD_W'(ctrl_i[take_idx][VEC_W-1:0]);
    end else if (msg_ack) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irqr_pkg::*;
#(
  parameter int LINES = 8,
  parameter int SEL_W = 8,
  parameter logic [31:0] DEST_RST = 32'h00FE_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_in,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             cfg_rvalid,
  output logic             msg_valid,
  input  logic             msg_ack,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data
);
  localparam int LW = $clog2(LINES);

  logic [LINES-1:0][WORD_W-1:0] ctrl_w;
  logic [LINES-1:0][WORD_W-1:0] dest_w;
  logic             eoi_valid;
  logic [VEC_W-1:0] eoi_vec;
  logic [LINES-1:0] msg_req;
  logic             take_valid;
  logic [LW-1:0]    take_idx;

  irqr_regs #(.LINES(LINES), .SEL_W(SEL_W), .DEST_RST(DEST_RST)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .ctrl_o(ctrl_w), .dest_o(dest_w),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec)
  );

  irqr_events #(.LINES(LINES)) u_events (
    .clk(clk), .rst(rst), .irq_in(irq_in), .ctrl_i(ctrl_w), .dest_i(dest_w),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .take_valid(take_valid),
    .take_idx(take_idx), .msg_req(msg_req)
  );

  irqr_sender #(.LINES(LINES)) u_sender (
    .clk(clk), .rst(rst), .msg_req(msg_req), .ctrl_i(ctrl_w), .dest_i(dest_w),
    .msg_ack(msg_ack), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .take_valid(take_valid), .take_idx(take_idx)
  );
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker (
  input logic        clk,
  input logic        rst,
  input logic        cfg_rd,
  input logic        cfg_rvalid,
  input logic        msg_valid,
  input logic        msg_ack,
  input logic [31:0] msg_addr,
  input logic [31:0] msg_data
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!msg_valid && !cfg_rvalid));

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> cfg_rvalid);

  assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> !cfg_rvalid);

  assert_vector_width_R4: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_data[31:6] == 26'd0));

  assert_addr_form_R6: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[31:28] == 4'hF && msg_addr[11:0] == 12'h000));

  assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

bind irq_redirect_ctrl irqr_checker u_chk (
  .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_rvalid(cfg_rvalid),
  .msg_valid(msg_valid), .msg_ack(msg_ack), .msg_addr(msg_addr),
  .msg_data(msg_data)
);

// File: tb/sim_irq_redirect_ctrl.sv
module sim_irq_redirect_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_in = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        msg_valid;
  logic        msg_ack = 1'b1;
  logic [31:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0;
  int failures = 0;
  logic [63:0] expq[$];

  irq_redirect_ctrl u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .msg_valid(msg_valid), .msg_ack(msg_ack),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: every accepted transfer is compared with the scoreboard head
  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ack) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4/R5/R7 unexpected message", {msg_addr, msg_data}, 64'd0);
      end else begin
        logic [63:0] e;
        e = expq.pop_front();
        chk({msg_addr, msg_data} == e, "R4/R6/R9 message", {msg_addr, msg_data}, e);
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(cfg_rvalid && cfg_rdata == exp, tag, {31'd0, cfg_rvalid, cfg_rdata}, {32'd1, exp});
  endtask

  task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
    reg_write(2'd0, {24'd0, idx});
    reg_write(2'd1, d);
  endtask

  task automatic win_read(input logic [7:0] idx, input logic [31:0] exp, input string tag);
    reg_write(2'd0, {24'd0, idx});
    reg_read(2'd1, exp, tag);
  endtask

  task automatic expect_msg(input logic [31:0] a, input logic [31:0] d);
    expq.push_back({a, d});
  endtask

  task automatic settle(input string tag);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, tag, 64'(expq.size()), 64'd0);
  endtask

  task automatic set_line(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!msg_valid, "R1 idle after reset", 64'(msg_valid), 64'd0);
    win_read(8'h10, 32'h0001_A002, "R1 line0 control reset");
    win_read(8'h1E, 32'h0001_A009, "R1 line7 control reset");
    win_read(8'h17, 32'h00FE_0000, "R1 line3 destination reset");

    // R3 special indices, R2 select readback
    win_read(8'h01, 32'h0020_0001, "R3 version word");
    win_write(8'h05, 32'h1234_5678);
    win_read(8'h05, 32'h0000_0000, "R3 low index reads zero");
    win_write(8'h40, 32'h0000_0000);
    win_read(8'h40, 32'hFFFF_FFFF, "R3 unmapped index");
    reg_read(2'd0, 32'h0000_0040, "R2 select readback");
    reg_read(2'd2, 32'h0000_0000, "R2 eoi register reads zero");

    // R5 masked line (reset state) delivers nothing
    set_line(0, 1'b1);
    settle("R5 masked line silent");
    set_line(0, 1'b0);

    // R4/R6 basic delivery
    win_write(8'h14, 32'h0000_0025);
    win_write(8'h15, 32'h3412_0000);
    expect_msg(32'hF123_4000, 32'h0000_0025);
    set_line(2, 1'b1);
    settle("R4 R6 single delivery");
    set_line(2, 1'b0);

    // R5 mode bits stored, zero destination blocks delivery
    win_write(8'h12, 32'h0000_A12A);
    win_read(8'h12, 32'h0000_A12A, "R5 mode bits readback");
    win_write(8'h13, 32'h0000_0000);
    set_line(1, 1'b1);
    settle("R5 zero destination silent");
    win_write(8'h13, 32'h0011_0000);
    set_line(1, 1'b0);
    expect_msg(32'hF110_0000, 32'h0000_002A);
    set_line(1, 1'b1);
    settle("R5 mode bits do not block");
    set_line(1, 1'b0);

    // R7 shared pending bit 5 between line 3 and line 4
    win_write(8'h16, 32'h0000_000D);
    win_write(8'h18, 32'h0000_0015);
    expect_msg(32'hFFE0_0000, 32'h0000_000D);
    set_line(3, 1'b1);
    settle("R7 first sharer delivers");
    set_line(4, 1'b1);
    settle("R7 second sharer suppressed");
    set_line(4, 1'b0);
    expect_msg(32'hFFE0_0000, 32'h0000_0015);
    set_line(4, 1'b1);
    settle("R7 fall clears pending");
    set_line(3, 1'b0);
    set_line(4, 1'b0);

    // R8 end of interrupt
    expect_msg(32'hFFE0_0000, 32'h0000_000D);
    set_line(3, 1'b1);
    settle("R8 setup delivery");
    reg_write(2'd2, 32'h0000_003F);
    set_line(4, 1'b1);
    settle("R8 nonmatching eoi keeps pending");
    set_line(4, 1'b0);
    set_line(3, 1'b0);
    expect_msg(32'hFFE0_0000, 32'h0000_000D);
    set_line(3, 1'b1);
    settle("R8 second setup delivery");
    reg_write(2'd2, 32'h0000_014D);
    expect_msg(32'hFFE0_0000, 32'h0000_0015);
    set_line(4, 1'b1);
    settle("R8 matching eoi clears pending");
    set_line(3, 1'b0);
    set_line(4, 1'b0);

    // R9 simultaneous lines, hold while not acknowledged
    win_write(8'h1A, 32'h0000_0030);
    win_write(8'h1C, 32'h0000_0031);
    win_write(8'h1E, 32'h0000_0032);
    @(negedge clk);
    msg_ack = 1'b0;
    irq_in[7:5] = 3'b111;
    repeat (4) @(negedge clk);
    chk(msg_valid && msg_data == 32'h30, "R9 lowest index offered first",
        {31'd0, msg_valid, msg_data}, {32'd1, 32'h30});
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_data == 32'h30 && msg_addr == 32'hFFE0_0000,
        "R9 held without ack", {msg_addr, msg_data}, {32'hFFE0_0000, 32'h30});
    expect_msg(32'hFFE0_0000, 32'h0000_0030);
    expect_msg(32'hFFE0_0000, 32'h0000_0031);
    expect_msg(32'hFFE0_0000, 32'h0000_0032);
    msg_ack = 1'b1;
    settle("R9 ordered drain");
    irq_in[7:5] = 3'b000;
    settle("R9 no extra messages");

    finish_run();
  end
endmodule